// File: doc/BRIEF.md
# Debug Trigger Match Qualifier and State Sequencer

This block sits behind a set of address comparators in an on-chip debug unit and turns their hits into steps of a small state sequencer. Each comparator channel is qualified in one of two ways, chosen by a per-channel mode bit. In forced mode a hit runs through a short fixed delay and then steps the sequencer directly. In tagged mode the hit only marks the opcode being fetched; the mark rides along a modeled instruction queue and steps the sequencer when that opcode is executed, so a tagged match never fires before its instruction runs.

The sequencer has four states. State 0 is disarmed, an arm pulse enters state 1, and every qualified event moves it to the state programmed for the current state in a per-state next-state field. Entering the last state raises a done flag and freezes the sequencer until it is armed again. A sticky flag per channel records which channel caused each step; when several channels qualify in the same cycle only the lowest-numbered one counts.

Top module: `dbg_match_seq`

## Requirements
- R1: After reset `state_o` is 0, `done_o` is 0 and `flags_o` is all zero.
- R2: An `arm_i` pulse sets `state_o` to 1, clears `done_o` and `flags_o` at the next clock edge, and takes priority over any qualified event at that same edge.
- R3: `mode_tag_i[c]` = 0 puts channel c in forced mode and 1 puts it in tagged mode; a hit on a tagged channel never produces a forced step.
- R4: A forced-mode hit present in cycle c steps the sequencer at the clock edge that closes cycle c+2, whatever `fetch_i`, `exec_i` and `flush_i` do in between.
- R5: A step from state s loads the value of `next_cfg_i[2s+1:2s]` into `state_o`.
- R6: Every cycle with `fetch_i` high pushes one queue entry holding the tagged-mode channels that hit in that cycle (possibly none); the queue holds 3 entries and a fetch into a full queue with no same-cycle execute is discarded.
- R7: An `exec_i` cycle with a non-empty queue removes the oldest entry; if that entry holds any channel, the sequencer steps at that same edge.
- R8: `flush_i` empties the queue; a fetch or execute in the same cycle as a flush has no effect.
- R9: When several channels qualify at one edge, forced and tagged alike, only the lowest-numbered one steps the sequencer and only its flag is set.
- R10: Stepping into state 3 sets `done_o`; while `done_o` is high all events are ignored until the next arm.
- R11: In state 0 all events are ignored.
- R12: `flags_o` bits stay set across steps until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm pulse, enters state 1 |
| mode_tag_i | input | 4 | Per-channel mode: 1 tagged, 0 forced |
| next_cfg_i | input | 8 | Next-state field per state, 2 bits each, state s at bits 2s+1:2s |
| cmp_hit_i | input | 4 | Comparator hits, one bit per channel |
| fetch_i | input | 1 | Opcode fetch strobe, pushes a queue entry |
| exec_i | input | 1 | Execute strobe, retires the oldest queue entry |
| flush_i | input | 1 | Empties the instruction queue |
| state_o | output | 2 | Current sequencer state |
| done_o | output | 1 | Final state reached |
| flags_o | output | 4 | Sticky per-channel step cause flags |

## Verification
The bench samples the state on each of the three edges after a forced hit, so a pipeline one register too short or too long shows up as a step one cycle early or late. Tagged hits are placed behind untagged fetches, into a full queue and next to flushes; a queue that lost order, accepted a fourth entry or let a flush race an execute would step on the wrong execute. Simultaneous hits and a tagged retire landing on the same edge as a forced event expose an arbiter that picks the wrong channel or sets more than one flag. Arm colliding with an event, and events arriving while disarmed or done, catch a sequencer that lets the wrong source win.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

    // Keep only the lowest set bit of a vector (up to 32 channels).
    function automatic logic [31:0] lsb_isolate(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

endpackage

// File: rtl/dbg_force_pipe.sv
module dbg_force_pipe #(
    parameter int NUM_CH = 4,
    parameter int DLY    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] tag_i,
    output logic [NUM_CH-1:0] fire_o
);
    typedef struct packed {
        logic [DLY-1:0][NUM_CH-1:0] stg;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.stg[0] = hit_i & ~tag_i;
        for (int i = 1; i < DLY; i++) begin
            pipe_d.stg[i] = pipe_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign fire_o = pipe_q.stg[DLY-1];
endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] tag_i,
    input  logic              fetch_i,
    input  logic              exec_i,
    input  logic              flush_i,
    output logic [NUM_CH-1:0] taghit_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][NUM_CH-1:0] ent;
        logic [CW-1:0]                cnt;
    } queue_t;

    queue_t        qu_d, qu_q;
    logic [CW-1:0] fill;
    logic [NUM_CH-1:0] new_tag;

    assign new_tag = hit_i & tag_i;

    always_comb begin
        qu_d     = qu_q;
        taghit_o = '0;
        fill     = qu_q.cnt;
        if (flush_i) begin
            qu_d = '0;
        end else begin
            if (exec_i && (qu_q.cnt != '0)) begin
                taghit_o = qu_q.ent[0];
                for (int i = 0; i < DEPTH - 1; i++) begin
                    qu_d.ent[i] = qu_q.ent[i+1];
                end
                qu_d.ent[DEPTH-1] = '0;
                fill = qu_q.cnt - CW'(1);
            end
            if (fetch_i && (fill < CW'(DEPTH))) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == fill) qu_d.ent[i] = new_tag;
                end
                fill = fill + CW'(1);
            end
            qu_d.cnt = fill;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qu_q <= '0;
        else        qu_q <= qu_d;
    end
endmodule

// File: rtl/dbg_seq_core.sv
module dbg_seq_core
    import dbg_match_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_STATES = 4,
    parameter int SW         = $clog2(NUM_STATES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm_i,
    input  logic [NUM_CH-1:0]        ev_i,
    input  logic [NUM_STATES*SW-1:0] next_cfg_i,
    output logic [SW-1:0]            state_o,
    output logic                     done_o,
    output logic [NUM_CH-1:0]        flags_o
);
    localparam logic [SW-1:0] ST_IDLE  = '0;
    localparam logic [SW-1:0] ST_FIRST = SW'(1);
    localparam logic [SW-1:0] ST_FINAL = SW'(NUM_STATES - 1);

    typedef struct packed {
        logic [SW-1:0]     state;
        logic              done;
        logic [NUM_CH-1:0] flags;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic [31:0]       win_wide;
    logic [NUM_CH-1:0] win;
    logic [SW-1:0]     nxt;

    assign win_wide = lsb_isolate(32'(ev_i));
    assign win      = win_wide[NUM_CH-1:0];
    assign nxt      = next_cfg_i[int'(seq_q.state)*SW +: SW];

    always_comb begin
        seq_d = seq_q;
        if (arm_i) begin
            seq_d.state = ST_FIRST;
            seq_d.done  = 1'b0;
            seq_d.flags = '0;
        end else if ((seq_q.state != ST_IDLE) && !seq_q.done && (|ev_i)) begin
            seq_d.state = nxt;
            seq_d.flags = seq_q.flags | win;
            if (nxt == ST_FINAL) seq_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign state_o = seq_q.state;
    assign done_o  = seq_q.done;
    assign flags_o = seq_q.flags;
endmodule

// File: rtl/dbg_match_seq.sv
module dbg_match_seq #(
    parameter int NUM_CH     = 4,
    parameter int NUM_STATES = 4,
    parameter int Q_DEPTH    = 3,
    parameter int FORCE_DLY  = 2,
    parameter int SW         = $clog2(NUM_STATES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm_i,
    input  logic [NUM_CH-1:0]        mode_tag_i,
    input  logic [NUM_STATES*SW-1:0] next_cfg_i,
    input  logic [NUM_CH-1:0]        cmp_hit_i,
    input  logic                     fetch_i,
    input  logic                     exec_i,
    input  logic                     flush_i,
    output logic [SW-1:0]            state_o,
    output logic                     done_o,
    output logic [NUM_CH-1:0]        flags_o
);
    logic [NUM_CH-1:0] forced_ev;
    logic [NUM_CH-1:0] tagged_ev;
    logic [NUM_CH-1:0] any_ev;

    dbg_force_pipe #(.NUM_CH(NUM_CH), .DLY(FORCE_DLY)) u_force (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (cmp_hit_i),
        .tag_i  (mode_tag_i),
        .fire_o (forced_ev)
    );

    dbg_tag_queue #(.NUM_CH(NUM_CH), .DEPTH(Q_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (cmp_hit_i),
        .tag_i    (mode_tag_i),
        .fetch_i  (fetch_i),
        .exec_i   (exec_i),
        .flush_i  (flush_i),
        .taghit_o (tagged_ev)
    );

    assign any_ev = forced_ev | tagged_ev;

    dbg_seq_core #(.NUM_CH(NUM_CH), .NUM_STATES(NUM_STATES), .SW(SW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .ev_i       (any_ev),
        .next_cfg_i (next_cfg_i),
        .state_o    (state_o),
        .done_o     (done_o),
        .flags_o    (flags_o)
    );
endmodule

// File: rtl/dbg_match_seq_chk.sv
module dbg_match_seq_chk #(
    parameter int NUM_CH = 4,
    parameter int SW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_i,
    input logic [SW-1:0]     state_o,
    input logic              done_o,
    input logic [NUM_CH-1:0] flags_o
);
    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (state_o == SW'(1)) && !done_o && (flags_o == '0)); // R2

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> done_o && $stable(state_o) && $stable(flags_o)); // R10

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == '0) && !arm_i) |=> (state_o == '0) && $stable(flags_o)); // R11

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R12

    AST_ONE_FLAG_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> ($countones(flags_o & ~$past(flags_o)) <= 1)); // R9
endmodule

bind dbg_match_seq dbg_match_seq_chk #(.NUM_CH(NUM_CH), .SW(SW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .state_o (state_o),
    .done_o  (done_o),
    .flags_o (flags_o)
);

// File: tb/dbg_match_seq_bench.sv
module dbg_match_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0;
    logic [3:0] mode_tag_i = '0;
    logic [7:0] next_cfg_i = 8'b00_11_10_00;
    logic [3:0] cmp_hit_i = '0;
    logic       fetch_i = 1'b0;
    logic       exec_i = 1'b0;
    logic       flush_i = 1'b0;
    logic [1:0] state_o;
    logic       done_o;
    logic [3:0] flags_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_match_seq u_dbg_match_seq (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mode_tag_i(mode_tag_i),
        .next_cfg_i(next_cfg_i), .cmp_hit_i(cmp_hit_i), .fetch_i(fetch_i),
        .exec_i(exec_i), .flush_i(flush_i), .state_o(state_o),
        .done_o(done_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input logic [1:0] st,
                         input logic dn, input logic [3:0] fl);
        n_chk++;
        if (state_o !== st || done_o !== dn || flags_o !== fl) begin
            n_fail++;
            $display("FAIL %s: state=%0d done=%0b flags=%b expected state=%0d done=%0b flags=%b",
                     req, state_o, done_o, flags_o, st, dn, fl);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, return at the next falling edge.
    task automatic cyc(input logic [3:0] hit, input logic fet, input logic ex,
                       input logic fl, input logic ar);
        cmp_hit_i = hit; fetch_i = fet; exec_i = ex; flush_i = fl; arm_i = ar;
        @(negedge clk);
        cmp_hit_i = '0; fetch_i = 0; exec_i = 0; flush_i = 0; arm_i = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_disarmed();
        check("R1 reset", 2'd0, 1'b0, 4'b0000);
        cyc(4'b0001, 0, 0, 0, 0);
        idle(3);
        check("R11 disarmed ignores hit", 2'd0, 1'b0, 4'b0000);
    endtask

    task automatic t_forced_and_final();
        mode_tag_i = 4'b0000;
        cyc(4'b0000, 0, 0, 1, 1);
        check("R2 arm", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0010, 0, 0, 0, 0);
        check("R4 no step after first edge", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0000, 0, 1, 1, 0);
        check("R4 no step after second edge", 2'd1, 1'b0, 4'b0000);
        idle(1);
        check("R4 R5 step after third edge", 2'd2, 1'b0, 4'b0010);
        cyc(4'b0001, 0, 0, 0, 0);
        idle(2);
        check("R10 R12 final state done, flags kept", 2'd3, 1'b1, 4'b0011);
        cyc(4'b1111, 0, 0, 0, 0);
        idle(3);
        check("R10 done ignores hits", 2'd3, 1'b1, 4'b0011);
    endtask

    task automatic t_next_prog();
        mode_tag_i = 4'b0000;
        next_cfg_i = 8'b00_11_11_00;
        cyc(4'b0000, 0, 0, 0, 1);
        cyc(4'b0100, 0, 0, 0, 0);
        idle(2);
        check("R5 state1 to 3", 2'd3, 1'b1, 4'b0100);
        next_cfg_i = 8'b00_11_00_00;
        cyc(4'b0000, 0, 0, 0, 1);
        cyc(4'b0100, 0, 0, 0, 0);
        idle(2);
        check("R5 state1 to 0", 2'd0, 1'b0, 4'b0100);
        next_cfg_i = 8'b00_11_10_00;
    endtask

    task automatic t_tagged();
        mode_tag_i = 4'b0100;
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b0100, 1, 0, 0, 0);
        cyc(4'b0000, 1, 0, 0, 0);
        idle(3);
        check("R3 tagged hit gives no forced step", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R7 taghit at execute", 2'd2, 1'b0, 4'b0100);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R7 untagged execute no step", 2'd2, 1'b0, 4'b0100);
        // order: untagged fetch first, tagged second
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b0000, 1, 0, 0, 0);
        cyc(4'b0100, 1, 0, 0, 0);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R6 first execute retires untagged", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R6 second execute retires tagged", 2'd2, 1'b0, 4'b0100);
    endtask

    task automatic t_flush_full();
        mode_tag_i = 4'b0100;
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b0100, 1, 0, 0, 0);
        cyc(4'b0000, 0, 0, 1, 0);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R8 flush drops tag", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0100, 1, 0, 1, 0);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R8 fetch with flush dropped", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0100, 1, 0, 0, 0);
        cyc(4'b0000, 0, 1, 1, 0);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R8 execute with flush no step", 2'd1, 1'b0, 4'b0000);
        // full queue
        cyc(4'b0000, 1, 0, 0, 0);
        cyc(4'b0000, 1, 0, 0, 0);
        cyc(4'b0000, 1, 0, 0, 0);
        cyc(4'b0100, 1, 0, 0, 0);
        repeat (4) cyc(4'b0000, 0, 1, 0, 0);
        check("R6 fetch into full queue discarded", 2'd1, 1'b0, 4'b0000);
        cyc(4'b0100, 1, 0, 0, 0);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R6 queue usable after drain", 2'd2, 1'b0, 4'b0100);
    endtask

    task automatic t_priority();
        mode_tag_i = 4'b0000;
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b1010, 0, 0, 0, 0);
        idle(2);
        check("R9 lowest forced channel wins", 2'd2, 1'b0, 4'b0010);
        mode_tag_i = 4'b0001;
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b0001, 1, 0, 0, 0);
        cyc(4'b0010, 0, 0, 0, 0);
        idle(1);
        cyc(4'b0000, 0, 1, 0, 0);
        check("R9 tagged ch0 beats forced ch1", 2'd2, 1'b0, 4'b0001);
    endtask

    task automatic t_arm_prio();
        mode_tag_i = 4'b0000;
        cyc(4'b0000, 0, 0, 1, 1);
        cyc(4'b0001, 0, 0, 0, 0);
        idle(1);
        cyc(4'b0000, 0, 0, 0, 1);
        check("R2 arm beats same-edge event", 2'd1, 1'b0, 4'b0000);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_disarmed();
        t_forced_and_final();
        t_next_prog();
        t_tagged();
        t_flush_full();
        t_priority();
        t_arm_prio();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule